// File: doc/BRIEF.md
# Ping-pong transmit buffer controller

This block sits between a 32-bit host register bus and a byte-wide transmit stream. It holds two frame buffers, one per port, each paired with a small register window of three registers: frame length, global interrupt enable and command/control. Software fills a buffer with words, writes the frame length and then writes a command. The block then either streams the buffered bytes out over a valid/ready byte interface, or copies the first six buffer bytes into a station address register without sending anything.

A command stays pending, with its start bit reading back as 1, until the block has served it. While one port's frame is streaming, software can prepare and launch the other port. That port waits and follows as soon as the engine is free, so the two buffers alternate in ping-pong fashion. When a command completes, the block can raise a one-cycle interrupt pulse. Only the first port's global enable takes part in that gating.

Top module: `ppong_tx_ctrl`

## Requirements
- R1: After a synchronous reset, the length, enable and control registers of both ports read 0, and `tx_valid`, `irq` and `stn_addr` are 0.
- R2: `bus_waddr` is a word address. Its top bit selects port 0 or port 1, and the remaining bits give the word within that port's window. Window words 0 to BUF_BYTES/4-1 are buffer storage, readable and writable. Window words 2^(WADDR_W-1)-3, -2 and -1 are the length, enable and control registers. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R3: Writing the control register with bit 0 set and bit 1 clear sends the selected port's frame. The frame is the first `length` buffer bytes, taken from each word least significant byte first, and `tx_last` is high only with the final byte.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R5: Writing the control register with bits 0 and 1 both set loads `stn_addr` from buffer bytes 0 to 5, with byte 0 in `stn_addr[7:0]`. No byte is sent.
- R6: After a command completes, control bits 0 and 1 read back as 0 and every other written bit is kept. A control write with bit 0 clear starts nothing and is stored with bits 0 and 1 cleared.
- R7: On completion, `irq` pulses high for exactly one cycle when bit 3 of that port's control register and bit 31 of port 0's enable register are both set. Port 1's enable register is storage only.
- R8: While a port's control bit 0 or 1 reads back as 1, control writes to that port are ignored. Length and enable writes are still accepted, and the frame in flight keeps the length latched at its start.
- R9: A send command with length 0 completes without sending a byte and raises its interrupt if enabled.
- R10: A length above BUF_BYTES is clamped, and exactly BUF_BYTES bytes are sent.
- R11: A command written to one port while the other port's frame is streaming stays pending, with bit 0 reading 1, and its frame follows right after the current one.
- R12: Window words between the buffer and the register group read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_waddr | input | WADDR_W | Host word address, top bit selects the port |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid the cycle after `bus_rd` |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit byte accepted by the sink |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Marks the final byte of a frame |
| irq | output | 1 | One-cycle completion interrupt pulse |
| stn_addr | output | 48 | Station address loaded by the address command |

## Verification
The bench uses the default parameters: a 10-bit word address and a 2020-byte buffer, which gives an 11-bit length field. With these values, lengths from 2021 to 2047 can be written, so the clamp to a full buffer is exercised, and the gap words between the buffer and the register group exist. Because every buffer word can be filled with random data, a full 2020-byte frame checks the read-out counter across the whole buffer. A sink with a random ready signal causes back-pressure at every byte lane of a word.

// File: rtl/ppong_pkg.sv
package ppong_pkg;
  localparam int NPORT  = 2;
  localparam int DW     = 32;
  localparam int STN_W  = 48;
  localparam int BIT_S  = 0;
  localparam int BIT_P  = 1;
  localparam int BIT_I  = 3;
  localparam int BIT_GE = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WAIT, ST_OUT, ST_A0, ST_A1, ST_A2, ST_DONE
  } seq_state_t;
endpackage

// File: rtl/ppong_dpram.sv
module ppong_dpram #(
  parameter int AW = 10,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_rdata,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [W-1:0]  b_rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (a_en) a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/ppong_regs.sv
module ppong_regs
  import ppong_pkg::*;
#(
  parameter int WIN_W = 9,
  parameter int LEN_W = 11
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic                        rd,
  input  logic                        port,
  input  logic [WIN_W-1:0]            widx,
  input  logic [DW-1:0]               wdata,
  input  logic                        done,
  input  logic                        done_port,
  output logic [NPORT-1:0][LEN_W-1:0] len_o,
  output logic [NPORT-1:0]            pend_o,
  output logic [NPORT-1:0]            amode_o,
  output logic                        irq_o,
  output logic [DW-1:0]               rdata_o
);
  localparam logic [WIN_W-1:0] W_LEN  = WIN_W'(2 ** WIN_W - 3);
  localparam logic [WIN_W-1:0] W_GIE  = WIN_W'(2 ** WIN_W - 2);
  localparam logic [WIN_W-1:0] W_CTRL = WIN_W'(2 ** WIN_W - 1);

  logic [NPORT-1:0][DW-1:0] ctrl_w, gie_w;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [LEN_W-1:0] len_q;
    logic [DW-1:0]    gie_q, ctrl_q;
    logic             hit, busy;
    assign hit  = wr && (port == 1'(p));
    assign busy = ctrl_q[BIT_S] || ctrl_q[BIT_P];

    always_ff @(posedge clk) begin
      if (rst) begin
        len_q  <= '0;
        gie_q  <= '0;
        ctrl_q <= '0;
      end else begin
        if (hit && widx == W_LEN) len_q <= wdata[LEN_W-1:0];
        if (hit && widx == W_GIE) gie_q <= wdata;
        if (hit && widx == W_CTRL && !busy)
          ctrl_q <= wdata[BIT_S] ? wdata : (wdata & ~DW'(3));
        if (done && done_port == 1'(p)) begin
          ctrl_q[BIT_S] <= 1'b0;
          ctrl_q[BIT_P] <= 1'b0;
        end
      end
    end

    assign len_o[p]   = len_q;
    assign pend_o[p]  = ctrl_q[BIT_S];
    assign amode_o[p] = ctrl_q[BIT_P];
    assign ctrl_w[p]  = ctrl_q;
    assign gie_w[p]   = gie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      irq_o <= done && ctrl_w[done_port][BIT_I] && gie_w[0][BIT_GE];
      if (rd) begin
        case (widx)
          W_LEN:   rdata_o <= DW'(len_o[port]);
          W_GIE:   rdata_o <= gie_w[port];
          W_CTRL:  rdata_o <= ctrl_w[port];
          default: rdata_o <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ppong_txseq.sv
module ppong_txseq
  import ppong_pkg::*;
#(
  parameter int WADDR_W   = 10,
  parameter int LEN_W     = 11,
  parameter int BUF_BYTES = 2020
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NPORT-1:0]            pend,
  input  logic [NPORT-1:0]            amode,
  input  logic [NPORT-1:0][LEN_W-1:0] len,
  output logic                        mem_en,
  output logic [WADDR_W-1:0]          mem_addr,
  input  logic [DW-1:0]               mem_rdata,
  output logic                        tx_valid,
  input  logic                        tx_ready,
  output logic [7:0]                  tx_data,
  output logic                        tx_last,
  output logic [STN_W-1:0]            stn_addr,
  output logic                        done,
  output logic                        done_port
);
  localparam int WIN_W = WADDR_W - 1;
  localparam logic [LEN_W-1:0] MAXLEN = LEN_W'(BUF_BYTES);

  seq_state_t       st_q;
  logic             sel_q, pick;
  logic [WIN_W-1:0] word_q;
  logic [LEN_W-1:0] rem_q, len_sel, len_eff;
  logic [DW-1:0]    sh_q;
  logic [1:0]       bidx_q;

  assign pick    = pend[0] ? 1'b0 : 1'b1;
  assign len_sel = len[pick];
  assign len_eff = (len_sel > MAXLEN) ? MAXLEN : len_sel;

  assign mem_en    = (st_q == ST_RD) || (st_q == ST_A0) || (st_q == ST_A1);
  assign mem_addr  = {sel_q, word_q};
  assign tx_valid  = (st_q == ST_OUT);
  assign tx_data   = sh_q[7:0];
  assign tx_last   = tx_valid && (rem_q == LEN_W'(1));
  assign done      = (st_q == ST_DONE);
  assign done_port = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      sel_q    <= 1'b0;
      word_q   <= '0;
      rem_q    <= '0;
      sh_q     <= '0;
      bidx_q   <= '0;
      stn_addr <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (|pend) begin
          sel_q  <= pick;
          word_q <= '0;
          bidx_q <= '0;
          rem_q  <= len_eff;
          if (amode[pick])          st_q <= ST_A0;
          else if (len_eff == '0)   st_q <= ST_DONE;
          else                      st_q <= ST_RD;
        end
        ST_RD:   st_q <= ST_WAIT;
        ST_WAIT: begin
          sh_q <= mem_rdata;
          st_q <= ST_OUT;
        end
        ST_OUT: if (tx_ready) begin
          rem_q <= rem_q - LEN_W'(1);
          sh_q  <= {8'h00, sh_q[DW-1:8]};
          if (rem_q == LEN_W'(1)) begin
            st_q <= ST_DONE;
          end else if (bidx_q == 2'd3) begin
            bidx_q <= '0;
            word_q <= word_q + WIN_W'(1);
            st_q   <= ST_RD;
          end else begin
            bidx_q <= bidx_q + 2'd1;
          end
        end
        ST_A0: begin
          word_q <= word_q + WIN_W'(1);
          st_q   <= ST_A1;
        end
        ST_A1: begin
          stn_addr[31:0] <= mem_rdata;
          st_q <= ST_A2;
        end
        ST_A2: begin
          stn_addr[47:32] <= mem_rdata[15:0];
          st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ppong_tx_ctrl.sv
module ppong_tx_ctrl
  import ppong_pkg::*;
#(
  parameter int WADDR_W   = 10,
  parameter int BUF_BYTES = 2020
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [WADDR_W-1:0] bus_waddr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [7:0]         tx_data,
  output logic               tx_last,
  output logic               irq,
  output logic [47:0]        stn_addr
);
  localparam int WIN_W     = WADDR_W - 1;
  localparam int BUF_WORDS = BUF_BYTES / 4;
  localparam int LEN_W     = $clog2(BUF_BYTES + 1);

  logic                        port, is_buf, rsel_q;
  logic [WIN_W-1:0]            widx;
  logic [DW-1:0]               ram_rdata, reg_rdata, seq_rdata;
  logic [NPORT-1:0][LEN_W-1:0] len;
  logic [NPORT-1:0]            pend, amode;
  logic                        seq_en, done, done_port;
  logic [WADDR_W-1:0]          seq_addr;

  assign port   = bus_waddr[WADDR_W-1];
  assign widx   = bus_waddr[WIN_W-1:0];
  assign is_buf = widx < WIN_W'(BUF_WORDS);

  always_ff @(posedge clk) begin
    if (rst)         rsel_q <= 1'b0;
    else if (bus_rd) rsel_q <= is_buf;
  end
  assign bus_rdata = rsel_q ? ram_rdata : reg_rdata;

  ppong_dpram #(.AW(WADDR_W), .W(DW)) u_ram (
    .clk    (clk),
    .a_en   (bus_rd),
    .a_we   (bus_wr && is_buf),
    .a_addr (bus_waddr),
    .a_wdata(bus_wdata),
    .a_rdata(ram_rdata),
    .b_en   (seq_en),
    .b_addr (seq_addr),
    .b_rdata(seq_rdata)
  );

  ppong_regs #(.WIN_W(WIN_W), .LEN_W(LEN_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .port     (port),
    .widx     (widx),
    .wdata    (bus_wdata),
    .done     (done),
    .done_port(done_port),
    .len_o    (len),
    .pend_o   (pend),
    .amode_o  (amode),
    .irq_o    (irq),
    .rdata_o  (reg_rdata)
  );

  ppong_txseq #(.WADDR_W(WADDR_W), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend),
    .amode    (amode),
    .len      (len),
    .mem_en   (seq_en),
    .mem_addr (seq_addr),
    .mem_rdata(seq_rdata),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .stn_addr (stn_addr),
    .done     (done),
    .done_port(done_port)
  );
endmodule

// File: rtl/ppong_tx_chk.sv
module ppong_tx_chk (
  input logic        clk,
  input logic        rst,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        irq,
  input logic [47:0] stn_addr
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!tx_valid && !irq));

  assert_last_with_valid_R3: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_addr_load_silent_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(stn_addr) |-> !tx_valid);

  assert_irq_single_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

bind ppong_tx_ctrl ppong_tx_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_valid(tx_valid),
  .tx_ready(tx_ready),
  .tx_data (tx_data),
  .tx_last (tx_last),
  .irq     (irq),
  .stn_addr(stn_addr)
);

// File: tb/ppong_tx_ctrl_tb.sv
module ppong_tx_ctrl_tb;
  localparam int WADDR_W = 10;
  localparam int BUFB    = 2020;
  localparam int BUFW    = BUFB / 4;
  localparam int LENW    = 509;
  localparam int GIEW    = 510;
  localparam int CTLW    = 511;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               bus_wr = 1'b0, bus_rd = 1'b0;
  logic [WADDR_W-1:0] bus_waddr = '0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic               tx_valid, tx_last, irq;
  logic               tx_ready = 1'b0;
  logic [7:0]         tx_data;
  logic [47:0]        stn_addr;

  int checks = 0, errors = 0;
  int ready_mode = 0;
  int cap_n = 0, irq_n = 0;
  logic [7:0] cap_d [4096];
  logic       cap_l [4096];
  logic [31:0] model [2][512];
  logic gie0_on = 1'b0;

  always #10 clk = ~clk;

  ppong_tx_ctrl #(.WADDR_W(WADDR_W), .BUF_BYTES(BUFB)) u_dut (.*);

  always @(negedge clk) begin
    case (ready_mode)
      0: tx_ready = 1'($urandom_range(0, 1));
      1: tx_ready = 1'b0;
      default: tx_ready = 1'b1;
    endcase
    if (!rst && tx_valid && tx_ready) begin
      cap_d[cap_n % 4096] = tx_data;
      cap_l[cap_n % 4096] = tx_last;
      cap_n++;
    end
    if (!rst && irq) irq_n++;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all reqs): actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int p, input int w, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = WADDR_W'(p * 512 + w); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int p, input int w, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_waddr = WADDR_W'(p * 512 + w);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_done(input int p);
    logic [31:0] c;
    for (int i = 0; i < 20000; i++) begin
      rd(p, CTLW, c);
      if (c[1:0] == 2'b00) break;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input int p, input int k);
    return model[p][k / 4][8 * (k % 4) +: 8];
  endfunction

  // Send a frame and check bytes, last flag, irq and control readback.
  task automatic send(input int p, input int len, input bit ien, input logic [31:0] hi);
    int base, ib, n;
    logic [31:0] c, cw;
    base = cap_n; ib = irq_n;
    n = (len > BUFB) ? BUFB : len;
    cw = (hi & 32'hFFFF_FFF4) | 32'h1 | (32'(ien) << 3);
    wr(p, LENW, 32'(len));
    wr(p, CTLW, cw);
    wait_done(p);
    chk("R3 byte count", 64'(cap_n - base), 64'(n));
    for (int k = 0; k < n; k++) begin
      chk("R3 byte value", {56'h0, cap_d[(base + k) % 4096]}, {56'h0, exp_byte(p, k)});
      chk("R3 last flag", 64'(cap_l[(base + k) % 4096]), 64'(k == n - 1));
    end
    chk("R7 irq count", 64'(irq_n - ib), 64'(ien && gie0_on));
    rd(p, CTLW, c);
    chk("R6 control readback", 64'(c), 64'(cw & ~32'h3));
  endtask

  initial begin
    logic [31:0] d;
    int base, ib;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    for (int p = 0; p < 2; p++)
      for (int w = LENW; w <= CTLW; w++) begin
        rd(p, w, d);
        chk("R1 register reset", 64'(d), 64'h0);
      end
    chk("R1 tx_valid reset", 64'(tx_valid), 64'h0);
    chk("R1 stn_addr reset", 64'(stn_addr), 64'h0);

    // R2: fill both buffers, read back samples
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < BUFW; w++) begin
        model[p][w] = $urandom;
        wr(p, w, model[p][w]);
      end
    for (int i = 0; i < 12; i++) begin
      int p, w;
      p = $urandom_range(0, 1);
      w = (i == 0) ? 0 : (i == 1) ? BUFW - 1 : $urandom_range(0, BUFW - 1);
      rd(p, w, d);
      chk("R2 buffer readback", 64'(d), 64'(model[p][w]));
    end

    // R12: gap words
    wr(0, BUFW, 32'hDEAD_BEEF);
    rd(0, BUFW, d);
    chk("R12 gap word reads 0", 64'(d), 64'h0);
    wr(1, LENW - 1, 32'h1234_5678);
    rd(1, LENW - 1, d);
    chk("R12 gap word reads 0", 64'(d), 64'h0);
    rd(0, BUFW - 1, d);
    chk("R12 buffer untouched", 64'(d), 64'(model[0][BUFW - 1]));

    // R3 / R6 / R7 directed
    wr(0, GIEW, 32'h8000_0000); gie0_on = 1'b1;
    send(0, 37, 1'b1, 32'hA5A5_0000);
    send(1, 13, 1'b0, 32'h0);
    wr(0, GIEW, 32'h0); gie0_on = 1'b0;
    wr(1, GIEW, 32'h8000_0000);
    send(1, 5, 1'b1, 32'h0);
    rd(1, GIEW, d);
    chk("R7 port1 enable storage", 64'(d), 64'h8000_0000);

    // R5: address load
    wr(0, GIEW, 32'h8000_0000); gie0_on = 1'b1;
    base = cap_n; ib = irq_n;
    wr(1, CTLW, 32'h0000_000B);
    wait_done(1);
    chk("R5 stn_addr", 64'(stn_addr), {16'h0, model[1][1][15:0], model[1][0]});
    chk("R5 no bytes sent", 64'(cap_n - base), 64'h0);
    chk("R5 irq", 64'(irq_n - ib), 64'h1);
    rd(1, CTLW, d);
    chk("R6 control after address load", 64'(d), 64'h8);

    // R6: write without start
    base = cap_n; ib = irq_n;
    wr(0, CTLW, 32'h0000_00AA);
    repeat (6) @(negedge clk);
    rd(0, CTLW, d);
    chk("R6 no-start write stored", 64'(d), 64'hA8);
    chk("R6 no-start no bytes", 64'(cap_n - base), 64'h0);

    // R8: busy ignores control writes, accepts length/enable
    ready_mode = 1;
    base = cap_n;
    wr(0, LENW, 32'd8);
    wr(0, CTLW, 32'h9);
    wr(0, CTLW, 32'h3);
    rd(0, CTLW, d);
    chk("R8 control write ignored while busy", 64'(d), 64'h9);
    wr(0, LENW, 32'd20);
    rd(0, LENW, d);
    chk("R8 length accepted while busy", 64'(d), 64'd20);
    wr(0, GIEW, 32'h8000_0001);
    rd(0, GIEW, d);
    chk("R8 enable accepted while busy", 64'(d), 64'h8000_0001);
    ready_mode = 0;
    wait_done(0);
    chk("R8 latched length used", 64'(cap_n - base), 64'd8);
    chk("R8 stn_addr unchanged", 64'(stn_addr), {16'h0, model[1][1][15:0], model[1][0]});

    // R9: zero length
    send(0, 0, 1'b1, 32'h0);

    // R10: clamp
    send(0, 2047, 1'b0, 32'h0);

    // R11: pending on other port follows
    ready_mode = 1;
    base = cap_n;
    wr(1, LENW, 32'd6);
    wr(1, CTLW, 32'h1);
    wr(0, LENW, 32'd5);
    wr(0, CTLW, 32'h1);
    rd(0, CTLW, d);
    chk("R11 other port pending", 64'(d[0]), 64'h1);
    ready_mode = 0;
    wait_done(1);
    wait_done(0);
    chk("R11 total bytes", 64'(cap_n - base), 64'd11);
    for (int k = 0; k < 6; k++)
      chk("R11 first frame", {56'h0, cap_d[(base + k) % 4096]}, {56'h0, exp_byte(1, k)});
    for (int k = 0; k < 5; k++)
      chk("R11 second frame", {56'h0, cap_d[(base + 6 + k) % 4096]}, {56'h0, exp_byte(0, k)});

    // Random mix (R3, R4 via random ready, R7, R9)
    for (int i = 0; i < 20; i++) begin
      bit g;
      g = 1'($urandom_range(0, 1));
      wr(0, GIEW, {g, 31'h0}); gie0_on = g;
      send($urandom_range(0, 1), $urandom_range(0, 60), 1'($urandom_range(0, 1)),
           $urandom & 32'hFFFF_FF00);
    end

    summary();
    $finish;
  end
endmodule